// File: doc/BRIEF.md
# Memory Device Configuration Sequencer

This block brings a DDR pseudo-static memory device to a known setting straight after reset. It runs once, without software, through the register port of the memory controller. It works out the initial access latency from the system clock frequency and the clock ratio that the controller reports. It passes that latency to the controller core. It then builds the 16-bit value for the device's configuration register, writes it, and reads it back to confirm the write.

The latency is chosen from the bus clock frequency, which is the system clock frequency (parameter `SYS_CLK_HZ`) divided by the ratio input. Bands with upper limits of 85, 104, 133 and 166 MHz select 3, 4, 5 and 6 clocks. Any higher frequency selects 7 clocks. The ratio and the latency-mode input are sampled once, when the sequence starts.

The state machine has six states:
- `S_START` is the reset state. It samples the inputs and always moves to `S_CORE`.
- `S_CORE` sends the latency strobe. It always moves to `S_WRITE`.
- `S_WRITE` holds the write request. It moves to `S_PAUSE` on done.
- `S_PAUSE` keeps the port idle. It always moves to `S_READ`.
- `S_READ` holds the read request. It moves to `S_FINISH` on done.
- `S_FINISH` is terminal and is left only by reset.

Top module: `hram_cfg_seq`

## Requirements
- R1: While `rst_n` is low, `reg_req`, `core_lat_we`, `init_done` and `cfg_mismatch` are 0.
- R2: Let ratio 0 count as 1. For bus frequency f = floor(SYS_CLK_HZ / ratio), the latency in clocks is 3 if f ≤ 85 MHz, 4 if f ≤ 104 MHz, 5 if f ≤ 133 MHz, 6 if f ≤ 166 MHz, and 7 otherwise. The 4-bit device codes are 1110 (3 clocks), 1111 (4), 0000 (5), 0001 (6) and 0010 (7).
- R3: In the second cycle after reset is released, `core_lat_we` is high for exactly one cycle, with `core_lat` equal to the latency in clocks.
- R4: The configuration word has these fields:
  - bit 15 = 1 (normal operation, not power-down);
  - bits [14:12] = 111 (strongest drive);
  - bits [11:8] = 1111;
  - bits [7:4] = latency code;
  - bit 3 = fixed-latency flag;
  - bit 2 = 1 (legacy bursts);
  - bits [1:0] = 11 (32-byte bursts).
- R5: Bit 3 is 1 when `var_latency` is 0 and is 0 when `var_latency` is 1.
- R6: From the third cycle after reset release, `reg_req` = 1, `reg_we` = 1, `reg_addr` = 2 and `reg_wdata` = the word. These hold, unchanged, up to and including the cycle in which `reg_done` is 1.
- R7: After the write's done cycle, `reg_req` is 0 for exactly one cycle. Then `reg_req` = 1, `reg_we` = 0 and `reg_addr` = 2 hold up to and including the read's done cycle.
- R8: `reg_rdata` in the read's done cycle appears on `readback` from the next cycle. `cfg_mismatch` is 1 exactly when it differs from the written word.
- R9: After the read completes, `init_done` is 1 and stays 1, and `reg_req` stays 0, until the next reset.
- R10: Changes to `clk_ratio` and `var_latency` after the first cycle following reset release have no effect on `core_lat` or the word written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_ratio | input | 4 | System-to-bus clock ratio reported by the controller |
| var_latency | input | 1 | Controller runs in variable-latency mode |
| reg_req | output | 1 | Register operation request, held until done |
| reg_we | output | 1 | 1 = register write, 0 = register read |
| reg_addr | output | 4 | Device register address |
| reg_wdata | output | 16 | Register write value |
| reg_done | input | 1 | Controller has completed the current register operation |
| reg_rdata | input | 16 | Register read value, valid with done |
| core_lat | output | 3 | Latency in clocks for the controller core |
| core_lat_we | output | 1 | One-cycle strobe for `core_lat` |
| init_done | output | 1 | Sequence finished |
| readback | output | 16 | Value read back from the device |
| cfg_mismatch | output | 1 | Readback differs from the written word |

## Verification
The bench builds the block with `SYS_CLK_HZ` = 660 MHz. With that value, the ratios 1, 4, 5, 7 and 8 land in all five latency bands, and ratio 0 exercises the divide-by-one rule. The bench's controller model answers with done delays from zero to five cycles. This covers the zero-wait handshake and long hold periods. One run corrupts the read data to exercise the mismatch flag. Another run swaps the ratio and mode inputs in the middle of the sequence.

// File: rtl/hram_cfg_pkg.sv
package hram_cfg_pkg;

    typedef enum logic [2:0] {
        S_START  = 3'd0,
        S_CORE   = 3'd1,
        S_WRITE  = 3'd2,
        S_PAUSE  = 3'd3,
        S_READ   = 3'd4,
        S_FINISH = 3'd5
    } seq_state_t;

    localparam int CFG_W      = 16;
    localparam int CODE_W     = 4;
    localparam int CLK_CNT_W  = 3;
    localparam int BAND_CNT   = 4;
    localparam int MIN_CLOCKS = 3;
    localparam int ZERO_CODE_CLOCKS = 5;   // clocks whose device code is 0000

    // Upper limits of the bus-frequency bands, in Hz.
    localparam longint unsigned BAND_LIMIT [BAND_CNT] =
        '{64'd85_000_000, 64'd104_000_000, 64'd133_000_000, 64'd166_000_000};

    // Fixed field contents of the configuration word.
    localparam logic       NO_POWER_DOWN = 1'b1;
    localparam logic [2:0] DRIVE_MAX     = 3'b111;
    localparam logic [3:0] RSVD_ONES     = 4'b1111;
    localparam logic       LEGACY_BURST  = 1'b1;
    localparam logic [1:0] BURST_32B     = 2'b11;

    localparam int CFG0_ADDR = 2;

endpackage

// File: rtl/hram_lat_select.sv
module hram_lat_select
    import hram_cfg_pkg::*;
#(
    parameter longint unsigned SYS_CLK_HZ = 64'd100_000_000,
    parameter int              RATIO_W    = 4
) (
    input  logic [RATIO_W-1:0]   ratio,
    output logic [CLK_CNT_W-1:0] clocks,
    output logic [CODE_W-1:0]    code
);
    logic [RATIO_W-1:0] eff_ratio;
    logic [BAND_CNT-1:0] above;

    assign eff_ratio = (ratio == '0) ? RATIO_W'(1) : ratio;

    // floor(S/r) > L  <=>  S >= (L+1)*r ; avoids a divider.
    for (genvar i = 0; i < BAND_CNT; i++) begin : g_band
        assign above[i] = SYS_CLK_HZ >= ((BAND_LIMIT[i] + 64'd1) * 64'(eff_ratio));
    end

    assign clocks = CLK_CNT_W'(MIN_CLOCKS) + CLK_CNT_W'($countones(above));
    // Device code is the clock count minus five, modulo 16.
    assign code   = CODE_W'(clocks) - CODE_W'(ZERO_CODE_CLOCKS);

endmodule

// File: rtl/hram_cfg_word.sv
module hram_cfg_word
    import hram_cfg_pkg::*;
(
    input  logic [CODE_W-1:0] lat_code,
    input  logic              var_mode,
    output logic [CFG_W-1:0]  word
);
    assign word = {NO_POWER_DOWN, DRIVE_MAX, RSVD_ONES, lat_code,
                   ~var_mode, LEGACY_BURST, BURST_32B};
endmodule

// File: rtl/hram_cfg_seq.sv
module hram_cfg_seq
    import hram_cfg_pkg::*;
#(
    parameter longint unsigned SYS_CLK_HZ = 64'd100_000_000,
    parameter int              RATIO_W    = 4,
    parameter int              ADDR_W     = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [RATIO_W-1:0]   clk_ratio,
    input  logic                 var_latency,
    output logic                 reg_req,
    output logic                 reg_we,
    output logic [ADDR_W-1:0]    reg_addr,
    output logic [CFG_W-1:0]     reg_wdata,
    input  logic                 reg_done,
    input  logic [CFG_W-1:0]     reg_rdata,
    output logic [CLK_CNT_W-1:0] core_lat,
    output logic                 core_lat_we,
    output logic                 init_done,
    output logic [CFG_W-1:0]     readback,
    output logic                 cfg_mismatch
);
    seq_state_t state, nxt;

    logic [RATIO_W-1:0] ratio_q;
    logic               var_q;
    logic [CODE_W-1:0]  lat_code;
    logic [CFG_W-1:0]   cfg_word;

    hram_lat_select #(.SYS_CLK_HZ(SYS_CLK_HZ), .RATIO_W(RATIO_W)) u_lat (
        .ratio  (ratio_q),
        .clocks (core_lat),
        .code   (lat_code)
    );

    hram_cfg_word u_word (
        .lat_code (lat_code),
        .var_mode (var_q),
        .word     (cfg_word)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_START;
        else        state <= nxt;
    end

    // Transitions
    always_comb begin
        nxt = state;
        unique case (state)
            S_START:  nxt = S_CORE;
            S_CORE:   nxt = S_WRITE;
            S_WRITE:  if (reg_done) nxt = S_PAUSE;
            S_PAUSE:  nxt = S_READ;
            S_READ:   if (reg_done) nxt = S_FINISH;
            S_FINISH: nxt = S_FINISH;
            default:  nxt = S_START;
        endcase
    end

    // Captured data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ratio_q      <= '0;
            var_q        <= 1'b0;
            readback     <= '0;
            cfg_mismatch <= 1'b0;
        end else begin
            if (state == S_START) begin
                ratio_q <= clk_ratio;
                var_q   <= var_latency;
            end
            if (state == S_READ && reg_done) begin
                readback     <= reg_rdata;
                cfg_mismatch <= (reg_rdata != cfg_word);
            end
        end
    end

    // Outputs
    always_comb begin
        reg_req     = 1'b0;
        reg_we      = 1'b0;
        core_lat_we = 1'b0;
        init_done   = 1'b0;
        unique case (state)
            S_START:  ;
            S_CORE:   core_lat_we = 1'b1;
            S_WRITE:  begin reg_req = 1'b1; reg_we = 1'b1; end
            S_PAUSE:  ;
            S_READ:   reg_req = 1'b1;
            S_FINISH: init_done = 1'b1;
            default:  ;
        endcase
    end

    assign reg_addr  = ADDR_W'(CFG0_ADDR);
    assign reg_wdata = cfg_word;

    // Assertions
    a_r3_core_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        core_lat_we |=> !core_lat_we);
    a_r6_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && !reg_done) |=> (reg_req && $stable(reg_we)));
    a_r6_wdata_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && reg_we && !reg_done) |=> $stable(reg_wdata));
    a_r7_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && reg_we && reg_done) |=> !reg_req);
    a_r8_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && !reg_we && reg_done) |=> (readback == $past(reg_rdata)));
    a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);
    a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> (!reg_req && !core_lat_we));

endmodule

// File: tb/hram_cfg_seq_test.sv
module hram_cfg_seq_test;

    localparam longint unsigned SYS_HZ = 64'd660_000_000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  clk_ratio = 4'd1;
    logic        var_latency = 1'b0;
    logic        reg_req, reg_we;
    logic [3:0]  reg_addr;
    logic [15:0] reg_wdata;
    logic        reg_done = 1'b0;
    logic [15:0] reg_rdata = 16'h0;
    logic [2:0]  core_lat;
    logic        core_lat_we, init_done, cfg_mismatch;
    logic [15:0] readback;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;   // 250 MHz

    hram_cfg_seq #(.SYS_CLK_HZ(SYS_HZ)) uut (
        .clk(clk), .rst_n(rst_n), .clk_ratio(clk_ratio), .var_latency(var_latency),
        .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_done(reg_done), .reg_rdata(reg_rdata), .core_lat(core_lat),
        .core_lat_we(core_lat_we), .init_done(init_done), .readback(readback),
        .cfg_mismatch(cfg_mismatch)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] got,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    function automatic int exp_clocks(input int r);
        longint unsigned f;
        f = SYS_HZ / longint'((r == 0) ? 1 : r);
        if (f <= 85_000_000)       return 3;
        else if (f <= 104_000_000) return 4;
        else if (f <= 133_000_000) return 5;
        else if (f <= 166_000_000) return 6;
        else                       return 7;
    endfunction

    function automatic logic [3:0] exp_code(input int c);
        case (c)
            3: return 4'b1110;
            4: return 4'b1111;
            5: return 4'b0000;
            6: return 4'b0001;
            default: return 4'b0010;
        endcase
    endfunction

    // phase: 0 start, 1 core, 2 write, 3 pause, 4 read, 5 finish
    task automatic run(input int r, input bit vmode, input int delay,
                       input logic [15:0] flip, input bit swap, input string tag);
        int phase = 0, wc = 0, fin = 0, cyc = 0;
        bit done_now;
        int clocks;
        logic [15:0] word;
        logic [15:0] stored;
        logic [15:0] rb_exp;
        logic [6:0] got_b, exp_b;

        clocks = exp_clocks(r);
        word = 16'h0000;
        word[15] = 1'b1;  word[14:12] = 3'b111; word[11:8] = 4'hF;
        word[7:4] = exp_code(clocks); word[3] = ~vmode; word[2] = 1'b1; word[1:0] = 2'b11;
        stored = 16'h0; rb_exp = 16'h0;

        @(negedge clk);
        rst_n = 1'b0; reg_done = 1'b0; reg_rdata = 16'h0;
        clk_ratio = 4'(r); var_latency = vmode;
        repeat (3) begin
            @(negedge clk);
            chk({reg_req, core_lat_we, init_done, cfg_mismatch} == 4'b0, {"R1 reset ", tag},
                {28'h0, reg_req, core_lat_we, init_done, cfg_mismatch}, 32'h0);
        end
        rst_n = 1'b1;
        while (fin < 6 && cyc < 300) begin
            // expected {req, we, addr, core_we, init_done}
            exp_b = {(phase == 2 || phase == 4), (phase == 2),
                     ((phase == 2 || phase == 4) ? 3'd2 : 3'd0),
                     (phase == 1), (phase == 5)};
            got_b = {reg_req, reg_we, (reg_req ? reg_addr[2:0] : 3'd0), core_lat_we, init_done};
            chk(got_b == exp_b, {"R6/R7/R9 sequence ", tag}, {25'h0, got_b}, {25'h0, exp_b});
            if (phase == 1)
                chk(core_lat == 3'(clocks), {"R2/R3 core latency ", tag},
                    {29'h0, core_lat}, clocks);
            if (phase == 2)
                chk(reg_wdata == word && reg_addr == 4'd2, {"R4/R5 word ", tag},
                    {12'h0, reg_addr, reg_wdata}, {12'h0, 4'd2, word});
            done_now = (phase == 2 || phase == 4) && wc == delay;
            reg_done  = done_now;
            reg_rdata = (done_now && phase == 4) ? (stored ^ flip) : 16'h0;
            if (swap && phase >= 1) begin
                clk_ratio   = 4'(r) ^ 4'hF;
                var_latency = ~vmode;
            end
            @(posedge clk);
            case (phase)
                0: phase = 1;
                1: begin phase = 2; wc = 0; end
                2: if (done_now) begin stored = word; phase = 3; end else wc++;
                3: begin phase = 4; wc = 0; end
                4: if (done_now) begin rb_exp = stored ^ flip; phase = 5; end else wc++;
                default: fin++;
            endcase
            @(negedge clk);
            reg_done = 1'b0;
            cyc++;
        end
        chk(cyc < 300, {"R9 completion ", tag}, cyc, 300);
        chk(readback == rb_exp, {"R8 readback ", tag}, {16'h0, readback}, {16'h0, rb_exp});
        chk(cfg_mismatch == (flip != 16'h0), {"R8 mismatch ", tag},
            {31'h0, cfg_mismatch}, {31'h0, (flip != 16'h0)});
        chk(init_done == 1'b1, {"R9 done held ", tag}, {31'h0, init_done}, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        run(1, 1'b0, 0, 16'h0000, 1'b0, "ratio1 fixed 7clk");
        run(4, 1'b1, 2, 16'h0000, 1'b0, "ratio4 R5 variable 6clk");
        run(5, 1'b0, 5, 16'h0040, 1'b0, "ratio5 5clk corrupt");
        run(7, 1'b0, 1, 16'h0000, 1'b1, "ratio7 R10 swap 4clk");
        run(8, 1'b1, 3, 16'h0000, 1'b0, "ratio8 3clk");
        run(0, 1'b0, 0, 16'h8000, 1'b1, "ratio0 R10 swap corrupt");
        summary();
        $finish;
    end

endmodule